// File: doc/BRIEF.md
# Dual-Port Mailbox Interrupt Flags

This block sits beside a shared two-port memory and gives each port a doorbell. Each port owns one mailbox word at the top of the address space. When one port writes the other port's mailbox word, the other port's interrupt flag is set. The receiving port clears its flag by reading its own mailbox word. While the flag is set, that port's active-low interrupt output is driven low.

Both ports are sampled on one clock edge. Each port presents four signals:
- an active-low chip enable;
- a read/write select, where low means write;
- an active-low output enable;
- an address.

Each port also has an active-low busy qualifier. While it is asserted, nothing that port does can change a flag. The mailbox contents live in the ordinary memory array and are not held here. If software never uses the interrupts, the two words behave as normal memory. The flag state has no effect on them. The interface is plain control and status with no data flow, so no valid/ready handshake is used.

Top module: `mbx_irq_top`

## Requirements
- R1: A synchronous reset (active-high `rst`) clears both flags, so `irq_a_n` and `irq_b_n` are both 1 after reset.
- R2: A port-B write sets flag A one cycle later, driving `irq_a_n` to 0. A write means `b_ce_n`=0 and `b_we_n`=0 at address `MBX_A` (0x7FE by default).
- R3: A port-A access clears flag A one cycle later, driving `irq_a_n` to 1. The access needs `a_ce_n`=0 and `a_oe_n`=0 at address `MBX_A`. The value of `a_we_n` does not matter.
- R4: A port-A write sets flag B one cycle later, driving `irq_b_n` to 0. The write needs `a_ce_n`=0 and `a_we_n`=0 at address `MBX_B` (0x7FF by default).
- R5: A port-B access clears flag B one cycle later, driving `irq_b_n` to 1. The access needs `b_ce_n`=0 and `b_oe_n`=0 at address `MBX_B`. The value of `b_we_n` does not matter.
- R6: A port whose busy input is low (`a_busy_n` or `b_busy_n`=0) changes neither flag, whether by setting or by clearing.
- R7: Accesses to any address other than the mailbox address in question leave the flags unchanged.
- R8: If a set and a clear of the same flag land in the same cycle, the flag ends up set.
- R9: When no qualifying event occurs, each flag holds its value. Each output is the inverse of its flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst | input | 1 | Synchronous reset, active high |
| a_ce_n | input | 1 | Port A chip enable, active low |
| a_we_n | input | 1 | Port A read/write, 0 = write |
| a_oe_n | input | 1 | Port A output enable, active low |
| a_addr | input | AW | Port A address |
| a_busy_n | input | 1 | Port A busy qualifier, active low |
| b_ce_n | input | 1 | Port B chip enable, active low |
| b_we_n | input | 1 | Port B read/write, 0 = write |
| b_oe_n | input | 1 | Port B output enable, active low |
| b_addr | input | AW | Port B address |
| b_busy_n | input | 1 | Port B busy qualifier, active low |
| irq_a_n | output | 1 | Port A interrupt, active low |
| irq_b_n | output | 1 | Port B interrupt, active low |

## Verification
The bench builds the block with its default 11-bit address, which puts the mailboxes at 0x7FE and 0x7FF. Random addresses are drawn mostly from the top four words, with the rest spread over the whole range. This steers stimulus toward the mailboxes and the words next to them, where neighbour hits, busy suppression and same-cycle set/clear collisions happen often. A reference model in the bench predicts both flags every cycle.

// File: rtl/mbx_irq_pkg.sv
package mbx_irq_pkg;
  typedef struct packed {
    logic ce_n;
    logic we_n;
    logic oe_n;
    logic busy_n;
  } port_ctl_t;
endpackage

// File: rtl/mbx_port_decode.sv
module mbx_port_decode #(
  parameter int AW = 11,
  parameter logic [AW-1:0] OWN_BOX = '1,
  parameter logic [AW-1:0] PEER_BOX = '1
) (
  input  mbx_irq_pkg::port_ctl_t ctl,
  input  logic [AW-1:0]          addr,
  output logic                   set_peer,
  output logic                   clr_own
);
  logic live;
  always_comb begin
    live     = !ctl.ce_n && ctl.busy_n;
    set_peer = live && !ctl.we_n && (addr == PEER_BOX);
    clr_own  = live && !ctl.oe_n && (addr == OWN_BOX);
  end
endmodule

// File: rtl/mbx_flag.sv
module mbx_flag (
  input  logic clk,
  input  logic rst,
  input  logic set_i,
  input  logic clr_i,
  output logic irq_n
);
  logic flag;
  always_ff @(posedge clk) begin
    if (rst) flag <= 1'b0;
    else if (set_i) flag <= 1'b1;
    else if (clr_i) flag <= 1'b0;
  end
  assign irq_n = ~flag;

  // R8
  set_wins_chk: assert property (@(posedge clk) disable iff (rst)
    set_i |=> !irq_n);
  // R3
  clr_only_chk: assert property (@(posedge clk) disable iff (rst)
    (clr_i && !set_i) |=> irq_n);
  // R9
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!set_i && !clr_i) |=> $stable(irq_n));
endmodule

// File: rtl/mbx_irq_top.sv
module mbx_irq_top #(
  parameter int AW = 11,
  localparam logic [AW-1:0] MBX_B = {AW{1'b1}},
  localparam logic [AW-1:0] MBX_A = MBX_B - 1'b1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          a_ce_n,
  input  logic          a_we_n,
  input  logic          a_oe_n,
  input  logic [AW-1:0] a_addr,
  input  logic          a_busy_n,
  input  logic          b_ce_n,
  input  logic          b_we_n,
  input  logic          b_oe_n,
  input  logic [AW-1:0] b_addr,
  input  logic          b_busy_n,
  output logic          irq_a_n,
  output logic          irq_b_n
);
  import mbx_irq_pkg::*;
  port_ctl_t a_ctl, b_ctl;
  logic set_b, clr_a, set_a, clr_b;

  assign a_ctl = '{ce_n: a_ce_n, we_n: a_we_n, oe_n: a_oe_n, busy_n: a_busy_n};
  assign b_ctl = '{ce_n: b_ce_n, we_n: b_we_n, oe_n: b_oe_n, busy_n: b_busy_n};

  mbx_port_decode #(.AW(AW), .OWN_BOX(MBX_A), .PEER_BOX(MBX_B)) u_dec_a (
    .ctl(a_ctl), .addr(a_addr), .set_peer(set_b), .clr_own(clr_a));
  mbx_port_decode #(.AW(AW), .OWN_BOX(MBX_B), .PEER_BOX(MBX_A)) u_dec_b (
    .ctl(b_ctl), .addr(b_addr), .set_peer(set_a), .clr_own(clr_b));

  mbx_flag u_flag_a (.clk(clk), .rst(rst), .set_i(set_a), .clr_i(clr_a), .irq_n(irq_a_n));
  mbx_flag u_flag_b (.clk(clk), .rst(rst), .set_i(set_b), .clr_i(clr_b), .irq_n(irq_b_n));

  // R1
  reset_state_chk: assert property (@(posedge clk) rst |=> (irq_a_n && irq_b_n));
  // R6
  busy_a_chk: assert property (@(posedge clk) disable iff (rst)
    (!a_busy_n && b_ce_n) |=> ($stable(irq_a_n) && $stable(irq_b_n)));
  // R6
  busy_b_chk: assert property (@(posedge clk) disable iff (rst)
    (!b_busy_n && a_ce_n) |=> ($stable(irq_a_n) && $stable(irq_b_n)));
  // R7
  far_addr_chk: assert property (@(posedge clk) disable iff (rst)
    (a_addr < MBX_A && b_addr < MBX_A) |=> ($stable(irq_a_n) && $stable(irq_b_n)));
  // R2
  set_a_chk: assert property (@(posedge clk) disable iff (rst)
    (!b_ce_n && !b_we_n && b_busy_n && b_addr == MBX_A) |=> !irq_a_n);
endmodule

// File: tb/tb_mbx_irq_top.sv
module tb_mbx_irq_top;
  localparam int AW = 11;
  localparam logic [AW-1:0] BOX_A = 11'h7FE;
  localparam logic [AW-1:0] BOX_B = 11'h7FF;

  logic clk = 0, rst = 1;
  logic a_ce_n = 1, a_we_n = 1, a_oe_n = 1, a_busy_n = 1;
  logic b_ce_n = 1, b_we_n = 1, b_oe_n = 1, b_busy_n = 1;
  logic [AW-1:0] a_addr = 0, b_addr = 0;
  logic irq_a_n, irq_b_n;
  int checks = 0, errors = 0;
  bit fa = 0, fb = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  mbx_irq_top #(.AW(AW)) dut (.*);

  function automatic bit next_flag(bit cur, bit s, bit c);
    if (s) return 1'b1;
    if (c) return 1'b0;
    return cur;
  endfunction

  function automatic bit wr_hit(logic ce, logic we, logic bz, logic [AW-1:0] ad,
                                logic [AW-1:0] box);
    return !ce && !we && bz && ad == box;
  endfunction

  function automatic bit rd_hit(logic ce, logic oe, logic bz, logic [AW-1:0] ad,
                                logic [AW-1:0] box);
    return !ce && !oe && bz && ad == box;
  endfunction

  task automatic check(string req, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  // Apply one cycle of stimulus, update the model, then check both outputs.
  task automatic step(string req);
    bit sa, ca, sb, cb;
    sa = wr_hit(b_ce_n, b_we_n, b_busy_n, b_addr, BOX_A);
    ca = rd_hit(a_ce_n, a_oe_n, a_busy_n, a_addr, BOX_A);
    sb = wr_hit(a_ce_n, a_we_n, a_busy_n, a_addr, BOX_B);
    cb = rd_hit(b_ce_n, b_oe_n, b_busy_n, b_addr, BOX_B);
    @(posedge clk);
    fa = next_flag(fa, sa, ca);
    fb = next_flag(fb, sb, cb);
    #1;
    check(req, irq_a_n, ~fa);
    check(req, irq_b_n, ~fb);
  endtask

  task automatic idle();
    a_ce_n = 1; a_we_n = 1; a_oe_n = 1; a_busy_n = 1;
    b_ce_n = 1; b_we_n = 1; b_oe_n = 1; b_busy_n = 1;
  endtask

  task automatic drv_a(logic ce, logic we, logic oe, logic bz, logic [AW-1:0] ad);
    a_ce_n = ce; a_we_n = we; a_oe_n = oe; a_busy_n = bz; a_addr = ad;
  endtask

  task automatic drv_b(logic ce, logic we, logic oe, logic bz, logic [AW-1:0] ad);
    b_ce_n = ce; b_we_n = we; b_oe_n = oe; b_busy_n = bz; b_addr = ad;
  endtask

  function automatic logic [AW-1:0] pick_addr();
    if ($urandom_range(3) != 0) return 11'h7FC + AW'($urandom_range(3));
    return AW'($urandom);
  endfunction

  initial begin
    void'($urandom(32'd1234));
    repeat (2) @(posedge clk);
    #1;
    check("R1", irq_a_n, 1'b1);
    check("R1", irq_b_n, 1'b1);
    @(negedge clk);
    rst = 0;

    // R2: port-B write to A's mailbox sets flag A
    drv_b(0, 0, 1, 1, BOX_A); step("R2"); idle(); step("R9");
    // R3: port-A access with we_n high clears flag A
    drv_a(0, 1, 0, 1, BOX_A); step("R3"); idle();
    // R4: port-A write to B's mailbox sets flag B
    drv_a(0, 0, 1, 1, BOX_B); step("R4"); idle();
    // R6: busy port B cannot clear flag B
    drv_b(0, 1, 0, 0, BOX_B); step("R6"); idle();
    check("R6", irq_b_n, 1'b0);
    // R5: port-B access with we_n low (a write) still clears flag B
    drv_b(0, 0, 0, 1, BOX_B); step("R5"); idle();
    // R6: busy port A cannot set flag B
    drv_a(0, 0, 1, 0, BOX_B); step("R6"); idle();
    check("R6", irq_b_n, 1'b1);
    // R7: writes to neighbouring words leave the flags alone
    drv_a(0, 0, 0, 1, 11'h7FD); drv_b(0, 0, 0, 1, 11'h7FD); step("R7"); idle();
    check("R7", irq_a_n, 1'b1);
    // R8: set and clear of flag A in the same cycle leave it set
    drv_b(0, 0, 1, 1, BOX_A); drv_a(0, 1, 0, 1, BOX_A); step("R8"); idle();
    check("R8", irq_a_n, 1'b0);
    // R7: port A writing its own mailbox does not set flag A
    drv_a(0, 0, 1, 1, BOX_A); step("R7"); idle();
    drv_a(0, 1, 0, 1, BOX_A); step("R3"); idle();

    // Random mix, checked against the model
    for (int i = 0; i < 3000; i++) begin
      drv_a(1'($urandom), 1'($urandom), 1'($urandom),
            1'($urandom_range(4) != 0), pick_addr());
      drv_b(1'($urandom), 1'($urandom), 1'($urandom),
            1'($urandom_range(4) != 0), pick_addr());
      step("R9");
    end

    // R1: reset mid-run returns both outputs high
    drv_a(0, 0, 1, 1, BOX_B); drv_b(0, 0, 1, 1, BOX_A); step("R2");
    idle(); rst = 1; @(posedge clk); #1;
    check("R1", irq_a_n, 1'b1);
    check("R1", irq_b_n, 1'b1);
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin repeat (100000) @(posedge clk); errors++; checks++;
        $display("FAIL watchdog actual=timeout expected=done"); end
    join_any
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule